// File: doc/BRIEF.md
# Streaming four-sample product unit

The unit takes a stream of signed 32-bit samples on a valid/ready input. It collects each run of four accepted samples and emits one word per run: the product of those four samples, wrapped to 32 bits in two's complement. One multiplier is time-shared. Starting with the acceptance of a run's last sample, it works through three registered steps, ((s0·s1)·s2)·s3. A run takes four cycles to arrive and the product takes three, so the product is done before the next run completes, and the input can accept one sample every clock.

Results leave on a valid/ready output that holds at most two words. One word sits on the output and one waits behind it. When the waiting slot is occupied, input ready is low. No product is ever dropped or reordered. A synchronous active-high reset throws away any partial run and empties the output.

Top module: `quad_product_stream`

## Requirements
- R1: Each group of four consecutively accepted samples produces exactly one output word. Output words appear in group order.
- R2: Each output word equals the product of the four samples of its group, truncated to the low 32 bits. With inputs 1 to 16, the outputs are 24, 1680, 11880 and 43680.
- R3: If out_ready stays high, in_ready stays high on every cycle, and one sample is accepted on each clock.
- R4: Assume the output is empty and the sequencer is idle. out_valid then first reads 1 after the second rising edge that follows the edge accepting a group's fourth sample. It reads 0 after the accepting edge and after the next edge.
- R5: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data does not change.
- R6: Up to two finished results are stored. While two are stored, in_ready is 0. Once out_ready takes one, input resumes. All stored results and later results come out in order.
- R7: After reset, out_valid is 0 and in_ready is 1. Samples accepted before reset belong to no group; the first sample after reset starts a new group.
- R8: Grouping counts accepted samples only. Idle cycles (in_valid 0) between samples do not move a sample into another group.
- R9: Signed operands multiply in two's complement, and overflow wraps silently. -2·3·4·5 gives 0xFFFFFF88, and 65536·65536·3·1 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is valid |
| in_ready | output | 1 | Unit can take a sample this cycle |
| in_data | input | 32 | Signed input sample |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Downstream takes the output word |
| out_data | output | 32 | Product of one group of four samples |

## Verification
The bench targets the exact arrival cycle of the first product. A sequencer that starts one cycle late, or that adds an extra stage, makes out_valid rise at the wrong edge. A long back-to-back stream with a ready output shows whether the next group's capture overwrites operands still in use: if it does, the products are corrupted. It also shows whether in_ready drops for no reason, which would stall the stream. Holding the output off across three groups shows whether a third result gets dropped or overwrites a stored one, and whether the input fails to stall. Idle gaps between samples and a reset in the middle of a group show whether the group index advances on anything other than an accepted sample, or survives reset.

// File: rtl/qps_pkg.sv
package qps_pkg;
  localparam int GROUP_N = 4;
  localparam int IDX_W   = $clog2(GROUP_N);

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_STEP1 = 2'd1,
    SEQ_STEP2 = 2'd2
  } seq_state_e;
endpackage

// File: rtl/qps_capture.sv
module qps_capture #(
  parameter int DATA_W = 32
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     accept,
  input  logic [DATA_W-1:0]                        sample,
  output logic [qps_pkg::GROUP_N-2:0][DATA_W-1:0]  held,
  output logic                                     grp_done
);
  localparam int LAST = qps_pkg::GROUP_N - 1;

  logic [qps_pkg::IDX_W-1:0] idx_q;

  assign grp_done = accept && (idx_q == qps_pkg::IDX_W'(LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (accept) begin
      if (idx_q == qps_pkg::IDX_W'(LAST)) idx_q <= '0;
      else                                idx_q <= idx_q + 1'b1;
    end
  end

  // The last sample of a group bypasses the buffer and goes straight to the sequencer.
  for (genvar g = 0; g < LAST; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (accept && idx_q == qps_pkg::IDX_W'(g)) held[g] <= sample;
    end
  end
endmodule

// File: rtl/qps_mul_seq.sv
module qps_mul_seq #(
  parameter int DATA_W = 32
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     start,
  input  logic [qps_pkg::GROUP_N-2:0][DATA_W-1:0]  held,
  input  logic [DATA_W-1:0]                        last_sample,
  output logic                                     busy,
  output logic                                     push,
  output logic [DATA_W-1:0]                        result
);
  import qps_pkg::*;

  function automatic logic [DATA_W-1:0] wrap_mul(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    wrap_mul = a * b;
  endfunction

  seq_state_e       state_q;
  logic [DATA_W-1:0] acc_q, op2_q, op3_q;
  logic [DATA_W-1:0] mul_a, mul_b, mul_y;

  always_comb begin
    case (state_q)
      SEQ_STEP1: begin mul_a = acc_q;   mul_b = op2_q;   end
      SEQ_STEP2: begin mul_a = acc_q;   mul_b = op3_q;   end
      default:   begin mul_a = held[0]; mul_b = held[1]; end
    endcase
  end

  assign mul_y  = wrap_mul(mul_a, mul_b);
  assign busy   = (state_q != SEQ_IDLE);
  assign push   = (state_q == SEQ_STEP2);
  assign result = mul_y;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
    end else begin
      case (state_q)
        SEQ_IDLE: if (start) begin
          acc_q   <= mul_y;
          op2_q   <= held[2];
          op3_q   <= last_sample;
          state_q <= SEQ_STEP1;
        end
        SEQ_STEP1: begin
          acc_q   <= mul_y;
          state_q <= SEQ_STEP2;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qps_out_buf.sv
module qps_out_buf #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              hold_full
);
  logic              spare_v;
  logic [DATA_W-1:0] spare_d;
  logic              pop;

  assign pop       = out_valid && out_ready;
  assign hold_full = spare_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      spare_v   <= 1'b0;
    end else begin
      if (!out_valid) begin
        if (push) begin out_valid <= 1'b1; out_data <= push_data; end
      end else if (pop) begin
        if (spare_v) begin
          out_data <= spare_d;
          spare_v  <= push;
          if (push) spare_d <= push_data;
        end else if (push) begin
          out_data <= push_data;
        end else begin
          out_valid <= 1'b0;
        end
      end else if (push) begin
        spare_v <= 1'b1;
        spare_d <= push_data;
      end
    end
  end
endmodule

// File: rtl/quad_product_stream.sv
module quad_product_stream #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic [qps_pkg::GROUP_N-2:0][DATA_W-1:0] held;
  logic              accept, grp_done, seq_busy, prod_push, hold_full;
  logic [DATA_W-1:0] prod_data;

  assign in_ready = !hold_full;
  assign accept   = in_valid && in_ready;

  qps_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .accept(accept), .sample(in_data),
    .held(held), .grp_done(grp_done)
  );

  qps_mul_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .start(grp_done), .held(held), .last_sample(in_data),
    .busy(seq_busy), .push(prod_push), .result(prod_data)
  );

  qps_out_buf #(.DATA_W(DATA_W)) u_obuf (
    .clk(clk), .rst(rst), .push(prod_push), .push_data(prod_data),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .hold_full(hold_full)
  );
endmodule

// File: rtl/qps_chk.sv
module qps_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              grp_done,
  input logic              seq_busy,
  input logic              prod_push,
  input logic              hold_full
);
  // R3
  seq_idle_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    grp_done |-> !seq_busy);
  // R4
  seq_starts_chk: assert property (@(posedge clk) disable iff (rst)
    grp_done |=> seq_busy);
  // R4
  product_latency_chk: assert property (@(posedge clk) disable iff (rst)
    grp_done |-> ##2 prod_push);
  // R5
  output_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R6
  no_drop_chk: assert property (@(posedge clk) disable iff (rst)
    prod_push |-> !(hold_full && out_valid && !out_ready));
  // R6
  full_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_full && !out_ready) |=> !in_ready);
endmodule

bind quad_product_stream qps_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .grp_done(grp_done),
  .seq_busy(seq_busy), .prod_push(prod_push), .hold_full(hold_full)
);

// File: tb/tb_quad_product_stream.sv
`timescale 1ns/1ps
module tb_quad_product_stream;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;

  always #4 clk = ~clk;

  quad_product_stream dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  // each row: four samples, then the expected product
  localparam logic [31:0] VEC [0:7][0:4] = '{
    '{32'd1, 32'd2, 32'd3, 32'd4, 32'd24},
    '{32'd5, 32'd6, 32'd7, 32'd8, 32'd1680},
    '{32'd9, 32'd10, 32'd11, 32'd12, 32'd11880},
    '{32'd13, 32'd14, 32'd15, 32'd16, 32'd43680},
    '{32'hFFFFFFFF, 32'd2, 32'hFFFFFFFD, 32'd4, 32'd24},
    '{32'hFFFFFFFE, 32'd3, 32'd4, 32'd5, 32'hFFFFFF88},
    '{32'd65536, 32'd65536, 32'd3, 32'd1, 32'd0},
    '{32'h7FFFFFFF, 32'd2, 32'd1, 32'd1, 32'hFFFFFFFE}
  };

  int checks = 0;
  int fails  = 0;
  int exp_n  = 0;
  int got_n  = 0;
  int stalls = 0;
  bit ii_watch = 1'b0;
  logic [31:0] exp_d [0:63];
  string       exp_t [0:63];

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_out(input logic [31:0] v, input string tag);
    exp_d[exp_n] = v;
    exp_t[exp_n] = tag;
    exp_n++;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // must be called just after a rising edge
  task automatic push(input logic [31:0] v);
    in_valid = 1'b1;
    in_data  = v;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 60 && got_n < exp_n; k++) @(negedge clk);
    check(got_n == exp_n, "R1 output count", 32'(got_n), 32'(exp_n));
  endtask

  always @(negedge clk) begin
    if (!rst && ii_watch && in_valid && !in_ready) stalls++;
    if (!rst && out_valid && out_ready) begin
      if (got_n >= exp_n) check(1'b0, "R1 unexpected output", out_data, 32'h0);
      else check(out_data == exp_d[got_n], exp_t[got_n], out_data, exp_d[got_n]);
      got_n++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    @(negedge clk);
    // R7 reset state
    check(out_valid == 1'b0, "R7 out_valid after reset", 32'(out_valid), 32'h0);
    check(in_ready == 1'b1, "R7 in_ready after reset", 32'(in_ready), 32'h1);
    tick();

    // R4 latency, R5 hold
    push(32'd2); push(32'd3); push(32'd4); push(32'd5);
    @(negedge clk);
    check(out_valid == 1'b0, "R4 not valid after accepting edge", 32'(out_valid), 32'h0);
    @(negedge clk);
    check(out_valid == 1'b0, "R4 not valid one edge later", 32'(out_valid), 32'h0);
    @(negedge clk);
    check(out_valid == 1'b1, "R4 valid two edges later", 32'(out_valid), 32'h1);
    check(out_data == 32'd120, "R4 first product", out_data, 32'd120);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b1, "R5 valid held", 32'(out_valid), 32'h1);
    check(out_data == 32'd120, "R5 data held", out_data, 32'd120);
    expect_out(32'd120, "R5 held word delivered");
    tick();
    out_ready = 1'b1;
    drain();

    // R1 R2 R9 table stream, R3 no stalls
    tick();
    ii_watch = 1'b1;
    for (int r = 0; r < 8; r++) begin
      expect_out(VEC[r][4], r < 4 ? "R2 product of group" : "R9 signed wrap product");
      for (int s = 0; s < 4; s++) push(VEC[r][s]);
    end
    ii_watch = 1'b0;
    drain();
    check(stalls == 0, "R3 stall cycles with ready output", 32'(stalls), 32'h0);

    // R6 two results stored, input stalls, nothing lost
    tick();
    out_ready = 1'b0;
    expect_out(32'd2,  "R6 first stored");
    expect_out(32'd3,  "R6 second stored");
    expect_out(32'd16, "R6 after stall");
    push(32'd1); push(32'd1); push(32'd1); push(32'd2);
    push(32'd1); push(32'd1); push(32'd1); push(32'd3);
    fork
      begin
        push(32'd2); push(32'd2); push(32'd2); push(32'd2);
      end
      begin
        repeat (10) @(negedge clk);
        check(in_ready == 1'b0, "R6 in_ready low while full", 32'(in_ready), 32'h0);
        check(out_data == 32'd2, "R6 oldest on output", out_data, 32'd2);
        tick();
        out_ready = 1'b1;
      end
    join
    drain();

    // R8 idle gaps between samples, with output ready toggling
    tick();
    expect_out(32'd210, "R8 gapped group");
    push(32'd2); repeat (3) tick();
    push(32'd3); tick(); out_ready = 1'b0;
    push(32'd5); repeat (2) tick();
    push(32'd7); repeat (5) tick();
    out_ready = 1'b1;
    drain();

    // R7 reset in mid-group discards partial samples
    tick();
    push(32'd7); push(32'd7);
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R7 out_valid after mid reset", 32'(out_valid), 32'h0);
    tick();
    expect_out(32'd3, "R7 group restarts after reset");
    push(32'd1); push(32'd1); push(32'd1); push(32'd3);
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule